// File: doc/BRIEF.md
# Interrupt Call Vector Byte Generator

This block supplies the bytes an interrupt controller places on the processor data bus while an interrupt is being acknowledged. It combines the programmed routine base address, the routine spacing choice (4 or 8 bytes), the processor mode and the 3-bit number of the level being serviced. Each acknowledge strobe makes it drive one byte on the next cycle, together with a drive-enable.

With an 8-bit processor the block produces a three-byte call sequence. The first byte is the call opcode, the second is the low byte of the routine address and the third is its high byte. The eight routines sit at equal spacing inside a 32-byte page (4-byte spacing) or a 64-byte page (8-byte spacing). The level number fills in the low address bits. With a 16-bit processor every acknowledge produces one vector byte: five programmed upper bits followed by the level number. Choosing which level to service and cascade handling are done elsewhere.

Top module: `intack_vector_gen`

## Requirements
- R1: After a synchronous reset, `bus_en_o` is 0, `bus_data_o` is 0 and the next 8-bit-mode byte is the first byte of the sequence.
- R2: In 8-bit mode (`cpu16_i`=0), the first acknowledge of a sequence drives the call opcode 0xCD.
- R3: With 4-byte spacing (`step4_i`=1), the second byte is {`addr_lo_i`[7:5], level[2:0], 2'b00}, so address bits 4:0 come from the level.
- R4: With 8-byte spacing (`step4_i`=0), the second byte is {`addr_lo_i`[7:6], level[2:0], 3'b000}, so address bits 5:0 come from the level.
- R5: The third byte is `addr_hi_i` unchanged. The acknowledge after it starts a new sequence with the opcode.
- R6: In 16-bit mode (`cpu16_i`=1), every acknowledge drives {`addr_hi_i`[7:3], level[2:0]}. `addr_lo_i`, `addr_hi_i`[2:0] and `step4_i` have no effect.
- R7: `bus_en_o` is 1 exactly in the cycle after a cycle with `ack_i`=1. When `bus_en_o` is 0, `bus_data_o` is 0.
- R8: Each driven byte uses the `level_i`, `addr_*` and `step4_i` values sampled on the same clock edge as the `ack_i` that requests it.
- R9: While `cpu16_i` is 1, the 8-bit sequence position is held at the first byte. The first 8-bit acknowledge after leaving 16-bit mode drives the opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ack_i | input | 1 | Acknowledge strobe, one byte per cycle high |
| cpu16_i | input | 1 | 1 = 16-bit processor format, 0 = 8-bit call sequence |
| step4_i | input | 1 | 1 = 4-byte routine spacing, 0 = 8-byte spacing |
| level_i | input | 3 | Level being serviced |
| addr_lo_i | input | 8 | Programmed low address byte (upper bits used) |
| addr_hi_i | input | 8 | Programmed high address byte / vector upper bits |
| bus_data_o | output | 8 | Byte driven onto the data bus |
| bus_en_o | output | 1 | Data bus drive-enable |

## Verification
The hardest situation to reach is a mode change in the middle of a call sequence. The 8-bit sequence position is internal and shows at the ports only through the next 8-bit byte. The stimulus therefore stops sequences after one or two bytes, switches into 16-bit mode for a few acknowledges, then switches back, and checks that the opcode comes first. Random runs vary the spacing, level and address on every strobe and insert idle gaps of random length between strobes.

// File: rtl/intack_vector_pkg.sv
package intack_vector_pkg;
  localparam int BYTE_W  = 8;
  localparam int LEVEL_W = 3;
  localparam int SEQ_LEN = 3;
  localparam int POS_W   = $clog2(SEQ_LEN);

  typedef enum logic [POS_W-1:0] {
    POS_OPCODE = 2'd0,
    POS_ADDR_LO = 2'd1,
    POS_ADDR_HI = 2'd2
  } seq_pos_e;
endpackage

// File: rtl/intack_seq_pos.sv
module intack_seq_pos
  import intack_vector_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     adv_i,
  input  logic     hold_i,
  output seq_pos_e pos_o
);
  seq_pos_e pos_q;

  always_ff @(posedge clk) begin
    if (rst || hold_i) begin
      pos_q <= POS_OPCODE;
    end else if (adv_i) begin
      unique case (pos_q)
        POS_OPCODE:  pos_q <= POS_ADDR_LO;
        POS_ADDR_LO: pos_q <= POS_ADDR_HI;
        default:     pos_q <= POS_OPCODE;
      endcase
    end
  end

  assign pos_o = pos_q;
endmodule

// File: rtl/intack_byte_fmt.sv
module intack_byte_fmt
  import intack_vector_pkg::*;
#(
  parameter logic [BYTE_W-1:0] CALL_OP = 8'hCD
) (
  input  seq_pos_e            pos_i,
  input  logic                cpu16_i,
  input  logic                step4_i,
  input  logic [LEVEL_W-1:0]  level_i,
  input  logic [BYTE_W-1:0]   addr_lo_i,
  input  logic [BYTE_W-1:0]   addr_hi_i,
  output logic [BYTE_W-1:0]   byte_o
);
  localparam int VEC_TOP_W = BYTE_W - LEVEL_W;

  logic [BYTE_W-1:0] lo_step4, lo_step8, vec16;

  always_comb begin
    lo_step4 = {addr_lo_i[BYTE_W-1 -: VEC_TOP_W-2], level_i, 2'b00};
    lo_step8 = {addr_lo_i[BYTE_W-1 -: VEC_TOP_W-3], level_i, 3'b000};
    vec16    = {addr_hi_i[BYTE_W-1 -: VEC_TOP_W], level_i};
  end

  always_comb begin
    if (cpu16_i) begin
      byte_o = vec16;
    end else begin
      unique case (pos_i)
        POS_OPCODE:  byte_o = CALL_OP;
        POS_ADDR_LO: byte_o = step4_i ? lo_step4 : lo_step8;
        default:     byte_o = addr_hi_i;
      endcase
    end
  end
endmodule

// File: rtl/intack_vector_gen.sv
module intack_vector_gen
  import intack_vector_pkg::*;
#(
  parameter logic [BYTE_W-1:0] CALL_OP = 8'hCD
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ack_i,
  input  logic               cpu16_i,
  input  logic               step4_i,
  input  logic [LEVEL_W-1:0] level_i,
  input  logic [BYTE_W-1:0]  addr_lo_i,
  input  logic [BYTE_W-1:0]  addr_hi_i,
  output logic [BYTE_W-1:0]  bus_data_o,
  output logic               bus_en_o
);
  seq_pos_e          pos;
  logic [BYTE_W-1:0] next_byte;

  intack_seq_pos u_pos (
    .clk    (clk),
    .rst    (rst),
    .adv_i  (ack_i),
    .hold_i (cpu16_i),
    .pos_o  (pos)
  );

  intack_byte_fmt #(.CALL_OP(CALL_OP)) u_fmt (
    .pos_i     (pos),
    .cpu16_i   (cpu16_i),
    .step4_i   (step4_i),
    .level_i   (level_i),
    .addr_lo_i (addr_lo_i),
    .addr_hi_i (addr_hi_i),
    .byte_o    (next_byte)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_data_o <= '0;
      bus_en_o   <= 1'b0;
    end else begin
      bus_en_o   <= ack_i;
      bus_data_o <= ack_i ? next_byte : '0;
    end
  end
endmodule

// File: rtl/intack_vector_chk.sv
module intack_vector_chk
  import intack_vector_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic               ack_i,
  input logic               cpu16_i,
  input logic [LEVEL_W-1:0] level_i,
  input logic [BYTE_W-1:0]  addr_hi_i,
  input seq_pos_e           pos,
  input logic [BYTE_W-1:0]  bus_data_o,
  input logic               bus_en_o
);
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !bus_en_o |-> bus_data_o == '0); // R7
  AST_EN_AFTER_ACK: assert property (@(posedge clk) disable iff (rst)
    ack_i |=> bus_en_o); // R7
  AST_QUIET_NO_ACK: assert property (@(posedge clk) disable iff (rst)
    !ack_i |=> !bus_en_o); // R7
  AST_OPCODE_FIRST: assert property (@(posedge clk) disable iff (rst)
    (ack_i && !cpu16_i && pos == POS_OPCODE) |=> bus_data_o == 8'hCD); // R2
  AST_HI_THEN_WRAP: assert property (@(posedge clk) disable iff (rst)
    (ack_i && !cpu16_i && pos == POS_ADDR_HI) |=> pos == POS_OPCODE); // R5
  AST_POS_LEGAL: assert property (@(posedge clk) disable iff (rst)
    pos != 2'd3); // R5
  AST_VEC16_FORMAT: assert property (@(posedge clk) disable iff (rst)
    (ack_i && cpu16_i) |=> bus_data_o == {$past(addr_hi_i[7:3]), $past(level_i)}); // R6
  AST_HOLD_IN_16: assert property (@(posedge clk) disable iff (rst)
    cpu16_i |=> pos == POS_OPCODE); // R9
endmodule

bind intack_vector_gen intack_vector_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .ack_i      (ack_i),
  .cpu16_i    (cpu16_i),
  .level_i    (level_i),
  .addr_hi_i  (addr_hi_i),
  .pos        (pos),
  .bus_data_o (bus_data_o),
  .bus_en_o   (bus_en_o)
);

// File: tb/intack_vector_gen_test.sv
module intack_vector_gen_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ack_i = 1'b0, cpu16_i = 1'b0, step4_i = 1'b0;
  logic [2:0] level_i = '0;
  logic [7:0] addr_lo_i = '0, addr_hi_i = '0;
  logic [7:0] bus_data_o;
  logic       bus_en_o;

  int checks = 0, fails = 0;
  int exp_pos = 0;
  bit done = 0;

  always #4 clk = ~clk;

  intack_vector_gen uut (
    .clk(clk), .rst(rst), .ack_i(ack_i), .cpu16_i(cpu16_i), .step4_i(step4_i),
    .level_i(level_i), .addr_lo_i(addr_lo_i), .addr_hi_i(addr_hi_i),
    .bus_data_o(bus_data_o), .bus_en_o(bus_en_o)
  );

  function automatic logic [7:0] model_byte(int p, bit m16, bit s4, logic [2:0] lv,
                                            logic [7:0] lo, logic [7:0] hi);
    if (m16) return {hi[7:3], lv};
    case (p)
      0: return 8'hCD;
      1: return s4 ? {lo[7:5], lv, 2'b00} : {lo[7:6], lv, 3'b000};
      default: return hi;
    endcase
  endfunction

  task automatic check(string req, logic [8:0] act, logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got en/data=%h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // Apply one cycle of inputs at negedge, check outputs at the next negedge.
  task automatic cycle(bit a, bit m16, bit s4, logic [2:0] lv,
                       logic [7:0] lo, logic [7:0] hi, string req);
    logic [7:0] e;
    ack_i = a; cpu16_i = m16; step4_i = s4; level_i = lv;
    addr_lo_i = lo; addr_hi_i = hi;
    e = a ? model_byte(exp_pos, m16, s4, lv, lo, hi) : 8'h00;
    if (m16) exp_pos = 0;
    else if (a) exp_pos = (exp_pos == 2) ? 0 : exp_pos + 1;
    @(posedge clk); @(negedge clk);
    check(req, {bus_en_o, bus_data_o}, {a, e});
  endtask

  initial begin
    int rep = 0;
    while (!done && rep < 100000) begin @(posedge clk); rep++; end
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: got hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1", {bus_en_o, bus_data_o}, 9'h000);
    // R2 R3 R5: 4-byte spacing full sequence
    cycle(1, 0, 1, 3'd5, 8'hE0, 8'h3A, "R2");
    cycle(1, 0, 1, 3'd5, 8'hE0, 8'h3A, "R3");
    cycle(1, 0, 1, 3'd5, 8'hE0, 8'h3A, "R5");
    cycle(1, 0, 1, 3'd5, 8'hE0, 8'h3A, "R5");  // wraps to opcode
    // R4: 8-byte spacing, low bits of addr_lo must vanish
    cycle(1, 0, 0, 3'd7, 8'hFF, 8'h12, "R4");
    cycle(1, 0, 0, 3'd7, 8'hFF, 8'h12, "R5");
    cycle(0, 0, 0, 3'd1, 8'hFF, 8'hFF, "R7");
    // R6: ignored bits change, output depends only on hi[7:3] and level
    cycle(1, 1, 1, 3'd2, 8'hAA, 8'hF8, "R6");
    cycle(1, 1, 0, 3'd2, 8'h55, 8'hFF, "R6");
    // R9: mid sequence entry into 16-bit mode then back
    cycle(1, 0, 1, 3'd1, 8'h20, 8'h40, "R2");
    cycle(1, 0, 1, 3'd1, 8'h20, 8'h40, "R3");
    cycle(0, 1, 1, 3'd1, 8'h20, 8'h40, "R9");
    cycle(1, 0, 1, 3'd1, 8'h20, 8'h40, "R9");
    // R8: level changes per strobe
    cycle(1, 0, 0, 3'd4, 8'h80, 8'h9C, "R8");
    cycle(1, 0, 0, 3'd6, 8'h80, 8'h9C, "R8");
    for (int i = 0; i < 2000; i++) begin
      bit a = ($urandom % 3) != 0;
      bit m = ($urandom % 5) == 0;
      cycle(a, m, 1'($urandom), 3'($urandom), 8'($urandom), 8'($urandom),
            m ? "R6" : (a ? "R8" : "R7"));
    end
    // R1: reset in mid sequence returns to opcode
    cycle(1, 0, 1, 3'd0, 8'h00, 8'h00, "R8");
    rst = 1'b1; exp_pos = 0;
    @(posedge clk); @(negedge clk);
    rst = 1'b0;
    check("R1", {bus_en_o, bus_data_o}, 9'h000);
    cycle(1, 0, 1, 3'd3, 8'h00, 8'h00, "R1");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule